// File: doc/BRIEF.md
# Two-Level Masked Interrupt Arbiter

This block collects interrupt requests from one non-maskable input, one address-break input and a parameterised set of maskable sources. Each maskable source has its own enable bit and a one-bit control level. Two mask bits held in the block, I and UI, decide which requests may pass. A level-0 source needs I clear. A level-1 source needs I or UI clear. The non-maskable and address-break requests always pass.

Among the requests that pass, the block picks one by fixed priority. It registers a request strobe and a vector number for the CPU. Both stay fixed until the CPU returns an acknowledge pulse. On that pulse the block sets both mask bits, so afterwards only the non-maskable and address-break inputs can interrupt until software clears a mask bit through the mask write port.

A two-word register port gives access to the enable and control-level bits.

Top module: `tl_irq_arb`

## Requirements
- R1: The vector number is 0 for the non-maskable request, 1 for address break and k+2 for maskable source k. Once `irq_req` is high it stays high with an unchanged `irq_vec` until a cycle with `cpu_ack` high. This holds even if the granted source drops or a higher request arrives.
- R2: A level-0 maskable source is granted only while I = 0. While I = 1 it is held pending.
- R3: A level-1 maskable source is granted when I = 0 or UI = 0. It is held pending only while both are 1.
- R4: The non-maskable and address-break requests are granted whatever the values of I and UI.
- R5: Priority, highest first, is: non-maskable, then level-1 sources by ascending index, then address break, then level-0 sources by ascending index. A request is registered on the first clock edge at which an eligible input is present while `irq_req` is low.
- R6: A maskable source whose enable bit is 0 is never granted.
- R7: On a clock edge with `irq_req` and `cpu_ack` both high, `irq_req` falls and both `mask_i` and `mask_ui` become 1. The non-maskable latch is cleared only when the acknowledged vector is 0.
- R8: A rising edge on `nmi_in` sets a latch, and the latch produces one request two clock edges after the input rises. A level that stays high does not request again. An edge that arrives while another vector is being held is kept and served next.
- R9: `mask_we` loads `mask_i` from `mask_wdata[0]` and `mask_ui` from `mask_wdata[1]` on the next edge. Arbitration uses the new values from the following edge on. An acknowledge in the same cycle takes precedence over the write.
- R10: With `reg_we` high, `reg_addr` = 0 writes the enable bits and `reg_addr` = 1 writes the control-level bits (1 = level 1). `reg_rdata` shows the register selected by `reg_addr`, registered one edge later.
- R11: After reset, `irq_req` = 0, `irq_vec` = 0, `mask_i` = `mask_ui` = 1, and all enable and level bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive |
| abrk_in | input | 1 | Address-break request, level |
| src_req | input | NUM_SRC | Maskable source requests, level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 enable, 1 level |
| reg_wdata | input | NUM_SRC | Register write data |
| reg_rdata | output | NUM_SRC | Registered read data of the selected register |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 2 | Bit 0 new I, bit 1 new UI |
| mask_i | output | 1 | Current I mask bit |
| mask_ui | output | 1 | Current UI mask bit |
| cpu_ack | input | 1 | Acknowledge of exception entry |
| irq_req | output | 1 | Interrupt request strobe to the CPU |
| irq_vec | output | VEC_W | Vector number of the held request |

## Verification
The bench targets the mask tier where I = 1 and UI = 0. A design that treated UI as a global enable would either pass level-0 sources there or block level-1 sources. It also places address break between the two levels in the priority order; swapped ranks show up as the wrong vector when both fire together.

It changes the pending sources while a request is held, which exposes a design that re-arbitrates before the acknowledge. It raises the non-maskable input while another vector is held, which catches a latch that is lost or cleared by the wrong acknowledge. It writes a mask bit in the same cycle as an acknowledge, and it checks the one-cycle delay from a mask write to a new grant.

// File: rtl/tl_irq_pkg.sv
package tl_irq_pkg;
  typedef enum logic {
    SEL_EN  = 1'b0,
    SEL_LVL = 1'b1
  } tl_reg_sel_e;

  localparam int VEC_NMI  = 0;
  localparam int VEC_ABRK = 1;
  localparam int VEC_SRC0 = 2;
endpackage

// File: rtl/tl_irq_regs.sv
module tl_irq_regs #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic               addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] rdata,
  output logic [NUM_SRC-1:0] en_bits,
  output logic [NUM_SRC-1:0] lvl_bits
);
  import tl_irq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_bits  <= '0;
      lvl_bits <= '0;
      rdata    <= '0;
    end else begin
      if (we && addr == SEL_EN)  en_bits  <= wdata;
      if (we && addr == SEL_LVL) lvl_bits <= wdata;
      rdata <= (addr == SEL_LVL) ? lvl_bits : en_bits;
    end
  end
endmodule

// File: rtl/tl_irq_mask.sv
module tl_irq_mask (
  input  logic       clk,
  input  logic       rst,
  input  logic       ack_set,
  input  logic       we,
  input  logic [1:0] wdata,
  output logic       mask_i,
  output logic       mask_ui
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_i  <= 1'b1;
      mask_ui <= 1'b1;
    end else if (ack_set) begin
      mask_i  <= 1'b1;
      mask_ui <= 1'b1;
    end else if (we) begin
      mask_i  <= wdata[0];
      mask_ui <= wdata[1];
    end
  end
endmodule

// File: rtl/tl_irq_pick.sv
module tl_irq_pick #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 4
) (
  input  logic               nmi_pend,
  input  logic               abrk,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] en_bits,
  input  logic [NUM_SRC-1:0] lvl_bits,
  input  logic               mask_i,
  input  logic               mask_ui,
  output logic               win_valid,
  output logic [VEC_W-1:0]   win_vec
);
  import tl_irq_pkg::*;

  logic [NUM_SRC-1:0] elig1, elig0;
  logic               hit1, hit0;
  logic [VEC_W-1:0]   idx1, idx0;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_elig
    assign elig1[k] = req[k] & en_bits[k] &  lvl_bits[k] & ~(mask_i & mask_ui);
    assign elig0[k] = req[k] & en_bits[k] & ~lvl_bits[k] & ~mask_i;
  end

  always_comb begin
    hit1 = 1'b0;
    hit0 = 1'b0;
    idx1 = '0;
    idx0 = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (elig1[k]) begin
        hit1 = 1'b1;
        idx1 = VEC_W'(k);
      end
      if (elig0[k]) begin
        hit0 = 1'b1;
        idx0 = VEC_W'(k);
      end
    end
  end

  always_comb begin
    win_valid = 1'b1;
    if (nmi_pend)  win_vec = VEC_W'(VEC_NMI);
    else if (hit1) win_vec = VEC_W'(VEC_SRC0) + idx1;
    else if (abrk) win_vec = VEC_W'(VEC_ABRK);
    else if (hit0) win_vec = VEC_W'(VEC_SRC0) + idx0;
    else begin
      win_valid = 1'b0;
      win_vec   = '0;
    end
  end
endmodule

// File: rtl/tl_irq_arb.sv
module tl_irq_arb #(
  parameter int NUM_SRC = 8,
  localparam int VEC_W  = $clog2(NUM_SRC + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               nmi_in,
  input  logic               abrk_in,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               reg_we,
  input  logic               reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  input  logic               mask_we,
  input  logic [1:0]         mask_wdata,
  output logic               mask_i,
  output logic               mask_ui,
  input  logic               cpu_ack,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec
);
  import tl_irq_pkg::*;

  logic [NUM_SRC-1:0] en_bits, lvl_bits;
  logic               nmi_q, nmi_pend;
  logic               win_valid;
  logic [VEC_W-1:0]   win_vec;
  logic               ack_take;

  assign ack_take = irq_req & cpu_ack;

  tl_irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .en_bits(en_bits), .lvl_bits(lvl_bits)
  );

  tl_irq_mask u_mask (
    .clk(clk), .rst(rst), .ack_set(ack_take), .we(mask_we), .wdata(mask_wdata),
    .mask_i(mask_i), .mask_ui(mask_ui)
  );

  tl_irq_pick #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_pick (
    .nmi_pend(nmi_pend), .abrk(abrk_in), .req(src_req), .en_bits(en_bits),
    .lvl_bits(lvl_bits), .mask_i(mask_i), .mask_ui(mask_ui),
    .win_valid(win_valid), .win_vec(win_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q <= nmi_in;
      if (nmi_in && !nmi_q)
        nmi_pend <= 1'b1;
      else if (ack_take && irq_vec == VEC_W'(VEC_NMI))
        nmi_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else if (irq_req) begin
      if (cpu_ack) irq_req <= 1'b0;
    end else if (win_valid) begin
      irq_req <= 1'b1;
      irq_vec <= win_vec;
    end
  end
endmodule

// File: rtl/tl_irq_arb_chk.sv
module tl_irq_arb_chk #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               cpu_ack,
  input logic               irq_req,
  input logic [VEC_W-1:0]   irq_vec,
  input logic               mask_i,
  input logic               mask_ui,
  input logic               mask_we,
  input logic [1:0]         mask_wdata,
  input logic               nmi_pend,
  input logic [NUM_SRC-1:0] en_bits,
  input logic [NUM_SRC-1:0] lvl_bits
);
  import tl_irq_pkg::*;

  logic [NUM_SRC-1:0] en_d, lvl_d;
  logic               g_en, g_lvl, g_src;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d  <= '0;
      lvl_d <= '0;
    end else begin
      en_d  <= en_bits;
      lvl_d <= lvl_bits;
    end
  end

  always_comb begin
    g_en  = 1'b0;
    g_lvl = 1'b0;
    g_src = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (irq_vec == VEC_W'(VEC_SRC0 + k)) begin
        g_en  = en_d[k];
        g_lvl = lvl_d[k];
        g_src = 1'b1;
      end
    end
  end

  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req && !cpu_ack |=> irq_req && $stable(irq_vec));

  // R7
  ack_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req && cpu_ack |=> mask_i && mask_ui && !irq_req);

  // R9
  mask_wr_chk: assert property (@(posedge clk) disable iff (rst)
    mask_we && !(irq_req && cpu_ack) |=>
      mask_i == $past(mask_wdata[0]) && mask_ui == $past(mask_wdata[1]));

  // R8
  nmi_first_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_pend && !irq_req |=> irq_req && irq_vec == VEC_W'(VEC_NMI));

  // R6
  grant_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) && g_src |-> g_en);

  // R2
  lvl0_mask_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) && g_src && !g_lvl |-> !$past(mask_i));

  // R3
  lvl1_mask_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) && g_src && g_lvl |-> !($past(mask_i) && $past(mask_ui)));
endmodule

bind tl_irq_arb tl_irq_arb_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_ack(cpu_ack), .irq_req(irq_req), .irq_vec(irq_vec),
  .mask_i(mask_i), .mask_ui(mask_ui), .mask_we(mask_we), .mask_wdata(mask_wdata),
  .nmi_pend(nmi_pend), .en_bits(en_bits), .lvl_bits(lvl_bits)
);

// File: tb/tl_irq_arb_bench.sv
module tl_irq_arb_bench;
  localparam int N  = 8;
  localparam int VW = $clog2(N + 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nmi_in = 1'b0, abrk_in = 1'b0;
  logic [N-1:0] src_req = '0;
  logic reg_we = 1'b0, reg_addr = 1'b0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic mask_we = 1'b0;
  logic [1:0] mask_wdata = '0;
  logic mask_i, mask_ui;
  logic cpu_ack = 1'b0;
  logic irq_req;
  logic [VW-1:0] irq_vec;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tl_irq_arb #(.NUM_SRC(N)) u_tl_irq_arb (
    .clk(clk), .rst(rst), .nmi_in(nmi_in), .abrk_in(abrk_in), .src_req(src_req),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_i(mask_i), .mask_ui(mask_ui),
    .cpu_ack(cpu_ack), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic sel, input logic [N-1:0] d);
    reg_we = 1'b1; reg_addr = sel; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic wr_mask(input logic i, input logic ui);
    mask_we = 1'b1; mask_wdata = {ui, i};
    tick();
    mask_we = 1'b0;
  endtask

  task automatic do_ack();
    cpu_ack = 1'b1;
    tick();
    cpu_ack = 1'b0;
  endtask

  // expected winner {valid, vector} from the priority and mask rules
  function automatic logic [VW:0] exp_pick(input logic nmi, input logic ab,
      input logic [N-1:0] en, input logic [N-1:0] lvl, input logic [N-1:0] rq,
      input logic i, input logic ui);
    if (nmi) return {1'b1, VW'(0)};
    for (int k = 0; k < N; k++)
      if (rq[k] && en[k] && lvl[k] && !(i && ui)) return {1'b1, VW'(k + 2)};
    if (ab) return {1'b1, VW'(1)};
    for (int k = 0; k < N; k++)
      if (rq[k] && en[k] && !lvl[k] && !i) return {1'b1, VW'(k + 2)};
    return '0;
  endfunction

  task automatic run_case(input string tag, input logic [N-1:0] en, input logic [N-1:0] lvl,
      input logic [N-1:0] rq, input logic ab, input logic i, input logic ui);
    logic [VW:0] e;
    wr_reg(1'b0, en);
    wr_reg(1'b1, lvl);
    wr_mask(i, ui);
    src_req = rq; abrk_in = ab;
    tick();
    e = exp_pick(1'b0, ab, en, lvl, rq, i, ui);
    check({tag, " req"}, 32'(irq_req), 32'(e[VW]));
    if (e[VW]) check({tag, " vec"}, 32'(irq_vec), 32'(e[VW-1:0]));
    if (irq_req) begin
      do_ack();
      check("R7 req drop", 32'(irq_req), 0);
      check("R7 masks set", 32'({mask_ui, mask_i}), 3);
    end
    src_req = '0; abrk_in = 1'b0;
    tick();
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1));
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R11 reset state
    check("R11 irq_req", 32'(irq_req), 0);
    check("R11 irq_vec", 32'(irq_vec), 0);
    check("R11 masks", 32'({mask_ui, mask_i}), 3);
    reg_addr = 1'b0; tick();
    check("R11 enable bits", 32'(reg_rdata), 0);
    reg_addr = 1'b1; tick();
    check("R11 level bits", 32'(reg_rdata), 0);

    // R10 register port
    wr_reg(1'b0, 8'hA5);
    wr_reg(1'b1, 8'h3C);
    reg_addr = 1'b0; tick();
    check("R10 enable readback", 32'(reg_rdata), 32'h A5);
    reg_addr = 1'b1; tick();
    check("R10 level readback", 32'(reg_rdata), 32'h3C);

    // R2 and R9: level-0 source held by I, released one cycle after the write
    wr_reg(1'b0, 8'h08);
    wr_reg(1'b1, 8'h00);
    wr_mask(1'b1, 1'b0);
    src_req = 8'h08;
    tick(); tick();
    check("R2 level0 held while I=1", 32'(irq_req), 0);
    wr_mask(1'b0, 1'b0);
    check("R9 no grant on write edge", 32'(irq_req), 0);
    tick();
    check("R9 grant after write", 32'(irq_req), 1);
    check("R2 level0 vector", 32'(irq_vec), 5);
    do_ack();
    src_req = '0; tick();

    // R3 level-1 passes with I=1 UI=0, held with both set
    run_case("R3 lvl1 UI=0", 8'h40, 8'h40, 8'h40, 1'b0, 1'b1, 1'b0);
    run_case("R3 lvl1 both set", 8'h40, 8'h40, 8'h40, 1'b0, 1'b1, 1'b1);
    // R4 address break with both masks set
    run_case("R4 abrk masked", 8'hFF, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b1);
    // R6 disabled source ignored
    run_case("R6 disabled", 8'hF7, 8'h00, 8'h08, 1'b0, 1'b0, 1'b0);
    // R5 ordering corners
    run_case("R5 lvl1 over abrk", 8'hFF, 8'h40, 8'h41, 1'b1, 1'b0, 1'b0);
    run_case("R5 abrk over lvl0", 8'hFF, 8'h00, 8'h03, 1'b1, 1'b0, 1'b0);
    run_case("R5 low index first", 8'hFF, 8'h14, 8'h14, 1'b0, 1'b0, 1'b0);

    // R1 hold while the inputs change
    wr_reg(1'b0, 8'hFF); wr_reg(1'b1, 8'h00); wr_mask(1'b0, 1'b0);
    src_req = 8'h10; tick();
    check("R1 initial vector", 32'(irq_vec), 6);
    src_req = 8'h01; abrk_in = 1'b1; tick(); tick();
    check("R1 still requesting", 32'(irq_req), 1);
    check("R1 vector stable", 32'(irq_vec), 6);
    // R9 acknowledge wins over a same-cycle mask write
    cpu_ack = 1'b1; mask_we = 1'b1; mask_wdata = 2'b00;
    tick();
    cpu_ack = 1'b0; mask_we = 1'b0; src_req = '0; abrk_in = 1'b0;
    check("R9 ack over write", 32'({mask_ui, mask_i}), 3);
    tick(); tick();

    // R8 NMI edge latency and no retrigger on a held level
    nmi_in = 1'b1; tick();
    check("R8 not yet", 32'(irq_req), 0);
    tick();
    check("R8 nmi request", 32'(irq_req), 1);
    check("R8 nmi vector", 32'(irq_vec), 0);
    do_ack();
    tick(); tick(); tick();
    check("R8 level no retrigger", 32'(irq_req), 0);
    nmi_in = 1'b0; tick();

    // R7 and R8: NMI edge during another held vector is kept
    abrk_in = 1'b1; tick();
    check("R4 abrk vector", 32'(irq_vec), 1);
    nmi_in = 1'b1; tick(); tick();
    abrk_in = 1'b0;
    do_ack();
    tick();
    check("R7 nmi latch kept", 32'(irq_req), 1);
    check("R8 nmi after abrk", 32'(irq_vec), 0);
    do_ack();
    nmi_in = 1'b0; tick(); tick();

    // random mix
    for (int n = 0; n < 60; n++) begin
      run_case("R5 random", N'($urandom), N'($urandom), N'($urandom),
               1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule